// File: doc/BRIEF.md
# Oscillator clock switch sequencer

This block carries out a change of the system clock source. Software writes a source code and raises a one-cycle go pulse. The block then raises its switch-enable flag and compares the requested source with the one currently in use. A request that names the current source, names an unused code, or jumps straight between the two PLL-based sources is dropped: switch-enable falls and nothing else changes.

For a valid request the block clears the PLL-lock and clock-fail status flags and turns on the oscillator, and the PLL if needed, that the new source uses. It then waits for the crystal start-up timer when the new source is a crystal, and for PLL lock when the new source uses the PLL. After that it counts a fixed number of new-clock ticks before it hands over. At handover it publishes the new source code, which steers the clock mux, and drops switch-enable. It also turns off the old oscillator, except that the low-power RC stays on while the watchdog or the fail-safe monitor needs it, and the secondary oscillator stays on while its keep-alive input is set.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset cur_src is 0 (fast RC), sw_en, pll_en, lock_sts and cf_sts are 0, and osc_en is 4'b0001.
- R2: Source codes are 0 fast RC, 1 fast RC with PLL, 2 primary crystal, 3 primary crystal with PLL, 4 secondary, 5 low-power RC. Codes 6 and 7 are unused. The osc_en bits are 0 fast RC, 1 primary, 2 secondary, 3 low-power RC. A PLL source also needs its base oscillator.
- R3: A sw_go pulse while sw_en is 0 sets sw_en at the next edge and captures req_src. A sw_go pulse while sw_en is 1 is ignored.
- R4: One edge after capture, a request equal to cur_src or using an unused code clears sw_en and leaves cur_src, osc_en, pll_en and both status flags unchanged.
- R5: A request from code 1 to 3 or from 3 to 1 is rejected in the same way as R4.
- R6: At the edge that accepts a request, lock_sts and cf_sts are cleared, and the oscillator bit and the PLL enable the new source needs are set. Enables already on stay on.
- R7: A crystal source (code 2 or 3) waits until ost_done is high, and then a PLL source (code 1 or 3) waits until pll_locked is high. lock_sts is set at the edge where that lock is taken.
- R8: Once the source is ready, handover happens at the edge that samples the 10th newclk_tick. With the tick held high and no waits, sw_en is high for 13 cycles.
- R9: At handover cur_src takes the requested code, sw_en falls and pll_en follows the new source.
- R10: At handover osc_en becomes the new source's need plus the old source's need, masked to low-power RC when wdt_en or fscm_en is 1 and to secondary when sosc_keep is 1.
- R11: cf_evt sets cf_sts, except at an accepting edge, where the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_go | input | 1 | One-cycle request to start a switch |
| req_src | input | 3 | Requested source code |
| ost_done | input | 1 | Crystal start-up timer expired |
| pll_locked | input | 1 | PLL reports lock |
| newclk_tick | input | 1 | One new-clock period seen in the system domain |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| sosc_keep | input | 1 | Keep the secondary oscillator running |
| cf_evt | input | 1 | Clock-fail event from the monitor |
| sw_en | output | 1 | Switch in progress |
| cur_src | output | 3 | Current source code, drives the clock mux select |
| osc_en | output | 4 | Per-oscillator enables |
| pll_en | output | 1 | PLL enable |
| lock_sts | output | 1 | PLL lock status |
| cf_sts | output | 1 | Clock-fail status |

## Verification
sw_en is due one edge after the go pulse. A rejection or acceptance shows one edge later. The crystal and PLL waits each take at least one edge. Handover lands on the edge that samples the tenth tick after ready. The bench runs a cycle model of these states that samples the same input values at each rising edge. All outputs are compared with it at every falling edge, so any result that comes one edge early or late is reported. Directed cases count the high cycles of sw_en (13 for an unhindered switch, 1 for a rejection) and check the enable masks right after handover.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SRC_W = 3;
  localparam int OSC_N = 4;

  typedef logic [SRC_W-1:0] src_code_t;
  typedef logic [OSC_N-1:0] osc_mask_t;

  localparam src_code_t SRC_FRC    = 3'd0;
  localparam src_code_t SRC_FRCPLL = 3'd1;
  localparam src_code_t SRC_PRI    = 3'd2;
  localparam src_code_t SRC_PRIPLL = 3'd3;
  localparam src_code_t SRC_SOSC   = 3'd4;
  localparam src_code_t SRC_LPRC   = 3'd5;

  localparam int OSC_FRC  = 0;
  localparam int OSC_PRI  = 1;
  localparam int OSC_SOSC = 2;
  localparam int OSC_LPRC = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_OST, ST_PLL, ST_SETTLE
  } seq_state_e;

  function automatic logic src_valid(input src_code_t c);
    return c <= SRC_LPRC;
  endfunction

  function automatic logic src_xtal(input src_code_t c);
    return (c == SRC_PRI) || (c == SRC_PRIPLL);
  endfunction

  function automatic logic src_pll(input src_code_t c);
    return (c == SRC_FRCPLL) || (c == SRC_PRIPLL);
  endfunction

  function automatic osc_mask_t src_need(input src_code_t c);
    osc_mask_t m;
    m = '0;
    case (c)
      SRC_FRC, SRC_FRCPLL: m[OSC_FRC]  = 1'b1;
      SRC_PRI, SRC_PRIPLL: m[OSC_PRI]  = 1'b1;
      SRC_SOSC:            m[OSC_SOSC] = 1'b1;
      SRC_LPRC:            m[OSC_LPRC] = 1'b1;
      default:             m = '0;
    endcase
    return m;
  endfunction

  function automatic logic pll_hop(input src_code_t from_c, input src_code_t to_c);
    return src_pll(from_c) && src_pll(to_c) && (from_c != to_c);
  endfunction

  function automatic logic request_ok(input src_code_t cur_c, input src_code_t tgt_c);
    return src_valid(tgt_c) && (tgt_c != cur_c) && !pll_hop(cur_c, tgt_c);
  endfunction

  function automatic osc_mask_t keep_mask(input logic wdt, input logic fscm, input logic sosc);
    osc_mask_t m;
    m = '0;
    m[OSC_LPRC] = wdt | fscm;
    m[OSC_SOSC] = sosc;
    return m;
  endfunction
endpackage

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_go,
  input  src_code_t  req_src,
  input  src_code_t  cur_src,
  input  logic       ost_done,
  input  logic       pll_locked,
  input  logic       settle_done,
  output logic       sw_en,
  output src_code_t  tgt_src,
  output seq_state_e state,
  output logic       evt_accept,
  output logic       evt_reject,
  output logic       evt_ost_pass,
  output logic       evt_ready,
  output logic       settle_run
);
  logic req_good;

  assign req_good     = request_ok(cur_src, tgt_src);
  assign evt_accept   = (state == ST_EVAL) && req_good;
  assign evt_reject   = (state == ST_EVAL) && !req_good;
  assign evt_ost_pass = (state == ST_OST) && (!src_xtal(tgt_src) || ost_done);
  assign evt_ready    = (state == ST_PLL) && (!src_pll(tgt_src) || pll_locked);
  assign settle_run   = (state == ST_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sw_en   <= 1'b0;
      tgt_src <= SRC_FRC;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sw_go) begin
            sw_en   <= 1'b1;
            tgt_src <= req_src;
            state   <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (req_good) begin
            state <= ST_OST;
          end else begin
            state <= ST_IDLE;
            sw_en <= 1'b0;
          end
        end
        ST_OST: begin
          if (evt_ost_pass) state <= ST_PLL;
        end
        ST_PLL: begin
          if (evt_ready) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_done) begin
            state <= ST_IDLE;
            sw_en <= 1'b0;
          end
        end
        default: begin
          state <= ST_IDLE;
          sw_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/clksw_settle.sv
module clksw_settle #(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && tick && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clksw_osc_gate.sv
module clksw_osc_gate
  import clksw_pkg::*;
#(
  parameter src_code_t RST_SRC = SRC_FRC
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt_accept,
  input  logic      evt_handover,
  input  src_code_t tgt_src,
  input  src_code_t cur_src,
  input  logic      wdt_en,
  input  logic      fscm_en,
  input  logic      sosc_keep,
  output osc_mask_t osc_en,
  output logic      pll_en
);
  osc_mask_t held_old;

  assign held_old = src_need(cur_src) & keep_mask(wdt_en, fscm_en, sosc_keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en <= src_need(RST_SRC);
      pll_en <= src_pll(RST_SRC);
    end else if (evt_handover) begin
      osc_en <= src_need(tgt_src) | held_old;
      pll_en <= src_pll(tgt_src);
    end else if (evt_accept) begin
      osc_en <= osc_en | src_need(tgt_src);
      pll_en <= pll_en | src_pll(tgt_src);
    end
  end
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
  import clksw_pkg::*;
#(
  parameter int        SETTLE_TICKS = 10,
  parameter src_code_t RST_SRC      = SRC_FRC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_go,
  input  logic [2:0] req_src,
  input  logic       ost_done,
  input  logic       pll_locked,
  input  logic       newclk_tick,
  input  logic       wdt_en,
  input  logic       fscm_en,
  input  logic       sosc_keep,
  input  logic       cf_evt,
  output logic       sw_en,
  output logic [2:0] cur_src,
  output logic [3:0] osc_en,
  output logic       pll_en,
  output logic       lock_sts,
  output logic       cf_sts
);
  src_code_t  tgt_src;
  seq_state_e seq_state;
  logic       evt_accept, evt_reject, evt_ost_pass, evt_ready;
  logic       settle_run, evt_handover;

  clksw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_go        (sw_go),
    .req_src      (req_src),
    .cur_src      (cur_src),
    .ost_done     (ost_done),
    .pll_locked   (pll_locked),
    .settle_done  (evt_handover),
    .sw_en        (sw_en),
    .tgt_src      (tgt_src),
    .state        (seq_state),
    .evt_accept   (evt_accept),
    .evt_reject   (evt_reject),
    .evt_ost_pass (evt_ost_pass),
    .evt_ready    (evt_ready),
    .settle_run   (settle_run)
  );

  clksw_settle #(.TICKS(SETTLE_TICKS)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (evt_ready),
    .run   (settle_run),
    .tick  (newclk_tick),
    .done  (evt_handover)
  );

  clksw_osc_gate #(.RST_SRC(RST_SRC)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_accept   (evt_accept),
    .evt_handover (evt_handover),
    .tgt_src      (tgt_src),
    .cur_src      (cur_src),
    .wdt_en       (wdt_en),
    .fscm_en      (fscm_en),
    .sosc_keep    (sosc_keep),
    .osc_en       (osc_en),
    .pll_en       (pll_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src  <= RST_SRC;
      lock_sts <= 1'b0;
      cf_sts   <= 1'b0;
    end else begin
      if (evt_handover) cur_src <= tgt_src;
      if (evt_accept) lock_sts <= 1'b0;
      else if (evt_ready && src_pll(tgt_src)) lock_sts <= 1'b1;
      if (evt_accept) cf_sts <= 1'b0;
      else if (cf_evt) cf_sts <= 1'b1;
    end
  end
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker
  import clksw_pkg::*;
#(
  parameter int SETTLE_TICKS = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_go,
  input logic       ost_done,
  input logic       pll_locked,
  input logic       newclk_tick,
  input logic       wdt_en,
  input logic       fscm_en,
  input logic       sosc_keep,
  input logic       sw_en,
  input logic [2:0] cur_src,
  input logic [3:0] osc_en,
  input logic       pll_en,
  input logic       lock_sts,
  input logic       cf_sts,
  input logic [2:0] tgt_src,
  input seq_state_e seq_state,
  input logic       evt_accept,
  input logic       evt_reject,
  input logic       evt_ready,
  input logic       settle_run,
  input logic       evt_handover
);
  logic [15:0] ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ticks_seen <= '0;
    else if (evt_ready) ticks_seen <= '0;
    else if (settle_run && newclk_tick) ticks_seen <= ticks_seen + 1'b1;
  end

  AST_BUSY_HOLDS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && sw_go) |=> $stable(tgt_src)); // R3
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> (!sw_en && $stable(cur_src) && $stable(osc_en) && $stable(pll_en))); // R4
  AST_NO_PLL_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |-> !(src_pll(cur_src) && src_pll(tgt_src))); // R5
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (!lock_sts && !cf_sts)); // R6
  AST_NEW_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (((osc_en & src_need(tgt_src)) == src_need(tgt_src)) && (pll_en || !src_pll(tgt_src)))); // R6
  AST_XTAL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_OST && src_xtal(tgt_src) && !ost_done) |=> (seq_state == ST_OST)); // R7
  AST_PLL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_PLL && src_pll(tgt_src) && !pll_locked) |=> (seq_state == ST_PLL)); // R7
  AST_SETTLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_handover |-> (newclk_tick && (ticks_seen == 16'(SETTLE_TICKS - 1)))); // R8
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    evt_handover |=> (!sw_en && (cur_src == $past(tgt_src)))); // R9
  AST_OLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_handover |=> ((osc_en & ~src_need($past(tgt_src))
                       & ~keep_mask($past(wdt_en), $past(fscm_en), $past(sosc_keep))) == 4'b0000)); // R10
endmodule

bind clk_switch_seq clksw_checker #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_go        (sw_go),
  .ost_done     (ost_done),
  .pll_locked   (pll_locked),
  .newclk_tick  (newclk_tick),
  .wdt_en       (wdt_en),
  .fscm_en      (fscm_en),
  .sosc_keep    (sosc_keep),
  .sw_en        (sw_en),
  .cur_src      (cur_src),
  .osc_en       (osc_en),
  .pll_en       (pll_en),
  .lock_sts     (lock_sts),
  .cf_sts       (cf_sts),
  .tgt_src      (tgt_src),
  .seq_state    (seq_state),
  .evt_accept   (evt_accept),
  .evt_reject   (evt_reject),
  .evt_ready    (evt_ready),
  .settle_run   (settle_run),
  .evt_handover (evt_handover)
);

// File: tb/tb_clk_switch_seq.sv
module tb_clk_switch_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_TICKS    = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_go = 1'b0, newclk_tick = 1'b0;
  logic [2:0] req_src = 3'd0;
  logic       wdt_en = 1'b0, fscm_en = 1'b0, sosc_keep = 1'b0, cf_evt = 1'b0;
  logic       ost_done, pll_locked;
  logic       sw_en, pll_en, lock_sts, cf_sts;
  logic [2:0] cur_src;
  logic [3:0] osc_en;

  int checks = 0, failures = 0, cycle_no = 0;
  int ost_dly = 3, pll_dly = 4, tick_pct = 100;
  bit rnd_mode = 0;
  int ost_cnt = 0, pll_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_switch_seq dut (
    .clk(clk), .rst_n(rst_n), .sw_go(sw_go), .req_src(req_src),
    .ost_done(ost_done), .pll_locked(pll_locked), .newclk_tick(newclk_tick),
    .wdt_en(wdt_en), .fscm_en(fscm_en), .sosc_keep(sosc_keep), .cf_evt(cf_evt),
    .sw_en(sw_en), .cur_src(cur_src), .osc_en(osc_en), .pll_en(pll_en),
    .lock_sts(lock_sts), .cf_sts(cf_sts)
  );

  // oscillator environment: start-up timer and PLL lock after programmable delays
  always @(posedge clk) begin
    ost_cnt <= osc_en[1] ? ((ost_cnt < 255) ? ost_cnt + 1 : ost_cnt) : 0;
    pll_cnt <= pll_en    ? ((pll_cnt < 255) ? pll_cnt + 1 : pll_cnt) : 0;
  end
  assign ost_done   = osc_en[1] && (ost_cnt >= ost_dly);
  assign pll_locked = pll_en && (pll_cnt >= pll_dly);

  // bench-side restatement of the source table (R2)
  function automatic logic [3:0] b_need(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return 4'b0001;
      3'd2, 3'd3: return 4'b0010;
      3'd4:       return 4'b0100;
      3'd5:       return 4'b1000;
      default:    return 4'b0000;
    endcase
  endfunction
  function automatic logic b_pll(input logic [2:0] c);
    return c == 3'd1 || c == 3'd3;
  endfunction
  function automatic logic b_xtal(input logic [2:0] c);
    return c == 3'd2 || c == 3'd3;
  endfunction
  function automatic logic b_ok(input logic [2:0] cur, input logic [2:0] nw);
    if (nw > 3'd5 || nw == cur) return 1'b0;
    if ((cur == 3'd1 && nw == 3'd3) || (cur == 3'd3 && nw == 3'd1)) return 1'b0;
    return 1'b1;
  endfunction

  // reference cycle model
  int         m_st;
  logic       m_sw, m_pll, m_lock, m_cf;
  logic [2:0] m_cur, m_tgt;
  logic [3:0] m_osc;
  int         m_ticks;
  logic       m_acc;
  assign m_acc = (m_st == 1) && b_ok(m_cur, m_tgt);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_sw <= 0; m_pll <= 0; m_lock <= 0; m_cf <= 0;
      m_cur <= 3'd0; m_tgt <= 3'd0; m_osc <= 4'b0001; m_ticks <= 0;
    end else begin
      case (m_st)
        0: if (sw_go) begin m_sw <= 1; m_tgt <= req_src; m_st <= 1; end
        1: if (m_acc) begin
             m_st <= 2; m_lock <= 0; m_osc <= m_osc | b_need(m_tgt);
             if (b_pll(m_tgt)) m_pll <= 1;
           end else begin
             m_st <= 0; m_sw <= 0;
           end
        2: if (!b_xtal(m_tgt) || ost_done) m_st <= 3;
        3: if (!b_pll(m_tgt) || pll_locked) begin
             m_st <= 4; m_ticks <= 0;
             if (b_pll(m_tgt)) m_lock <= 1;
           end
        default: if (newclk_tick) begin
             if (m_ticks == N_TICKS - 1) begin
               m_st <= 0; m_sw <= 0; m_cur <= m_tgt; m_pll <= b_pll(m_tgt);
               m_osc <= b_need(m_tgt) | (b_need(m_cur) & {wdt_en | fscm_en, sosc_keep, 2'b00});
             end else begin
               m_ticks <= m_ticks + 1;
             end
           end
      endcase
      if (m_acc) m_cf <= 0;
      else if (cf_evt) m_cf <= 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cycle_no);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic cyc();
    @(negedge clk);
    cycle_no++;
    if (cycle_no > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycle_no);
      finish_run();
    end
    if (rst_n) begin
      check("R3 sw_en", sw_en, m_sw);
      check("R9 cur_src", cur_src, m_cur);
      check("R10 osc_en", osc_en, m_osc);
      check("R6 pll_en", pll_en, m_pll);
      check("R7 lock_sts", lock_sts, m_lock);
      check("R11 cf_sts", cf_sts, m_cf);
    end
    sw_go  = 0;
    cf_evt = 0;
    if (rnd_mode) begin
      newclk_tick = ($urandom % 100) < tick_pct;
      if (m_st != 0 && ($urandom % 10) == 0) begin
        sw_go = 1; req_src = 3'($urandom);   // ignored while busy (R3)
      end
      cf_evt = ($urandom % 20) == 0;
    end
  endtask

  task automatic run_switch(input logic [2:0] code, output int hi);
    int guard;
    hi = 0; guard = 0;
    sw_go = 1; req_src = code;
    do begin
      cyc();
      if (sw_en) hi++;
      guard++;
    end while (m_st != 0 && guard < 2000);
  endtask

  initial begin
    int hi;
    void'($urandom(32'd20240611));
    newclk_tick = 1;
    repeat (3) cyc();
    // R1 reset state
    check("R1 cur_src", cur_src, 0);
    check("R1 sw_en", sw_en, 0);
    check("R1 osc_en", osc_en, 4'b0001);
    check("R1 pll_en", pll_en, 0);
    check("R1 status", {lock_sts, cf_sts}, 0);
    rst_n = 1;
    cyc();

    // R8: unhindered switch to low-power RC takes 13 busy cycles; R2 bit for code 5
    run_switch(3'd5, hi);
    check("R8 busy cycles", hi, 13);
    check("R2 lprc enable", osc_en, 4'b1000);
    check("R9 cur_src lprc", cur_src, 5);

    // R4: redundant and unused codes
    run_switch(3'd5, hi);
    check("R4 redundant busy", hi, 1);
    check("R4 redundant cur", cur_src, 5);
    run_switch(3'd7, hi);
    check("R4 unused busy", hi, 1);
    check("R4 unused osc_en", osc_en, 4'b1000);

    // R7: fast RC with PLL waits for lock
    pll_dly = 6;
    run_switch(3'd1, hi);
    check("R7 pll source cur", cur_src, 1);
    check("R7 lock set", lock_sts, 1);
    check("R2 frc with pll", {pll_en, osc_en}, 5'b10001);

    // R5: direct PLL-to-PLL hop rejected
    run_switch(3'd3, hi);
    check("R5 hop busy", hi, 1);
    check("R5 hop cur", cur_src, 1);
    check("R5 hop pll_en", pll_en, 1);

    // R7: crystal with PLL reached via fast RC
    run_switch(3'd0, hi);
    ost_dly = 8;
    run_switch(3'd3, hi);
    check("R7 xtal pll cur", cur_src, 3);
    check("R2 primary with pll", {pll_en, osc_en}, 5'b10010);

    // R10: low-power RC kept for watchdog
    run_switch(3'd5, hi);
    wdt_en = 1;
    run_switch(3'd0, hi);
    check("R10 lprc kept", osc_en, 4'b1001);
    wdt_en = 0;

    // R11: clock-fail event sets the flag
    cf_evt = 1;
    cyc();
    check("R11 cf set", cf_sts, 1);

    // random phase
    rnd_mode = 1;
    for (int i = 0; i < 400; i++) begin
      wdt_en    = ($urandom % 4) == 0;
      fscm_en   = ($urandom % 4) == 0;
      sosc_keep = ($urandom % 3) == 0;
      ost_dly   = $urandom % 13;
      pll_dly   = $urandom % 13;
      tick_pct  = 30 + ($urandom % 71);
      run_switch(($urandom % 5 == 0) ? 3'($urandom) : 3'($urandom % 6), hi);
      repeat ($urandom % 3) cyc();
    end
    rnd_mode = 0;
    finish_run();
  end
endmodule